// File: doc/BRIEF.md
# Fractional-N Phase Resync Timer

This block produces periodic sync events for the digital core of a fractional-N synthesizer. It runs on the phase-frequency-detector reference clock. The time between events is the product of two programmed values: a 4-bit multiplier and a 13-bit delay count. When a new frequency word arrives, the block arms itself and ignores the first sync event that follows. It then issues a single-cycle resync strobe on the second event, so the fractional accumulator is realigned only after the loop has had time to settle.

Settings arrive over a three-wire serial port: a shift clock, a data line and a latch line. The 13-bit value field is shared. A select bit in the control word decides whether the field writes the delay count or the fractional modulus. A sticky flag reports a delay count that is not a whole multiple of the modulus while the timer is enabled.

Top module: `resync_timer`

## Requirements
- R1: While enabled, `sync_evt` is high for exactly one reference cycle, once every MULT × DELAY reference cycles. For example, MULT 10 with DELAY 1000 gives 10000 cycles.
- R2: When MULT is 0, the timer is disabled: `sync_evt` and `resync_pulse` stay low.
- R3: A 24-bit word is shifted in MSB first on rising `ser_clk` edges. It takes effect a few reference cycles after `ser_latch` rises. Word bits 1:0 select the target: 00 is a frequency word, 01 is the control word, 10 is the value word.
- R4: In the control word, bit 23 is the select bit and bits 7:4 are MULT. A value word carries its 13-bit value in bits 15:3. The value goes to DELAY when the select bit is 1 and to the modulus when the select bit is 0.
- R5: After a frequency word, `resync_pulse` is high for one cycle. That cycle coincides with the second `sync_evt` following the load, and not with the first.
- R6: A frequency word received while the block waits for its second event restarts the event count from zero.
- R7: After the strobe, no further strobe occurs until another frequency word is loaded.
- R8: After a control or value write, `config_err` is 1 if MULT is nonzero and the modulus is 0, or if DELAY modulo the modulus is nonzero.
- R9: `config_err` changes only on a control or value write. It keeps its value across frequency words. A write that leaves a valid configuration clears it.
- R10: After reset, `sync_evt`, `resync_pulse` and `config_err` are 0 and the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (PFD) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch line; a rising edge commits the shifted word |
| sync_evt | output | 1 | One-cycle periodic sync event |
| resync_pulse | output | 1 | One-cycle phase realignment strobe |
| config_err | output | 1 | Sticky flag for a delay that is not a multiple of the modulus |

## Verification
The assertions check on every cycle that the strobe only appears together with a sync event, that it never lasts two cycles, and that it stays off while the multiplier is zero. They also check that the counters restart after each event and that the error flag moves only on a register write. Only the bench scenarios can show the period lengths, including the 10000-cycle reference case, and the choice of the second event rather than the first. The same holds for the restart on a repeated frequency load and for how the shared value field is routed by the select bit.

// File: rtl/resync_timer.sv
module resync_timer #(
  parameter int WORD_W = 24,
  parameter int MUL_W  = 4,
  parameter int CNT_W  = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ser_latch,
  output logic sync_evt,
  output logic resync_pulse,
  output logic config_err
);
  localparam int VAL_LSB = 3;
  localparam int MUL_LSB = 4;

  logic [WORD_W-1:0] shift_q;
  logic [2:0]        le_q;
  logic [MUL_W-1:0]  mul_q, mul_n, outer_q;
  logic [CNT_W-1:0]  dly_q, dly_n, mod_q, mod_n, inner_q;
  logic              sel_q, armed_q, seen_q, err_n;

  always_ff @(posedge ser_clk or negedge rst_n)
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[WORD_W-2:0], ser_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) le_q <= '0;
    else        le_q <= {le_q[1:0], ser_latch};

  wire wr_stb  = le_q[1] & ~le_q[2];
  wire wr_freq = wr_stb && shift_q[1:0] == 2'b00;
  wire wr_ctrl = wr_stb && shift_q[1:0] == 2'b01;
  wire wr_val  = wr_stb && shift_q[1:0] == 2'b10;

  assign mul_n = wr_ctrl ? shift_q[MUL_LSB +: MUL_W] : mul_q;
  assign dly_n = (wr_val && sel_q)  ? shift_q[VAL_LSB +: CNT_W] : dly_q;
  assign mod_n = (wr_val && !sel_q) ? shift_q[VAL_LSB +: CNT_W] : mod_q;
  assign err_n = (mul_n != '0) &&
                 ((mod_n == '0) ? 1'b1 : ((dly_n % mod_n) != '0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mul_q      <= '0;
      dly_q      <= '0;
      mod_q      <= '0;
      sel_q      <= 1'b0;
      config_err <= 1'b0;
    end else begin
      mul_q <= mul_n;
      dly_q <= dly_n;
      mod_q <= mod_n;
      if (wr_ctrl) sel_q <= shift_q[WORD_W-1];
      if (wr_ctrl || wr_val) config_err <= err_n;
    end

  wire en         = (mul_q != '0) && (dly_q != '0);
  wire inner_wrap = inner_q >= dly_q - CNT_W'(1);
  wire outer_wrap = outer_q >= mul_q - MUL_W'(1);

  assign sync_evt = en && inner_wrap && outer_wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      inner_q <= '0;
      outer_q <= '0;
    end else if (!en) begin
      inner_q <= '0;
      outer_q <= '0;
    end else if (inner_wrap) begin
      inner_q <= '0;
      outer_q <= outer_wrap ? '0 : outer_q + MUL_W'(1);
    end else begin
      inner_q <= inner_q + CNT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (wr_freq) begin
      armed_q <= 1'b1;
      seen_q  <= 1'b0;
    end else if (sync_evt && armed_q) begin
      armed_q <= !seen_q;
      seen_q  <= !seen_q;
    end

  assign resync_pulse = sync_evt && armed_q && seen_q && !wr_freq;
endmodule

// File: rtl/resync_timer_chk.sv
module resync_timer_chk #(
  parameter int MUL_W = 4,
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_evt,
  input logic             resync_pulse,
  input logic             config_err,
  input logic             wr_stb,
  input logic [MUL_W-1:0] mul_q,
  input logic [MUL_W-1:0] outer_q,
  input logic [CNT_W-1:0] inner_q
);
  assert_pulse_on_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |-> sync_evt);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |=> !resync_pulse);

  assert_no_pulse_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_q == '0) |-> !resync_pulse);

  assert_count_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> (inner_q == '0 && outer_q == '0));

  assert_err_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(config_err));
endmodule

bind resync_timer resync_timer_chk #(.MUL_W(MUL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt), .resync_pulse(resync_pulse),
  .config_err(config_err), .wr_stb(wr_stb), .mul_q(mul_q),
  .outer_q(outer_q), .inner_q(inner_q)
);

// File: tb/resync_timer_tb.sv
module resync_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
  logic sync_evt, resync_pulse, config_err;
  int   checks = 0, errors = 0;

  always #4 clk = ~clk;

  resync_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch), .sync_evt(sync_evt), .resync_pulse(resync_pulse),
    .config_err(config_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ctrl_w(input bit sel, input logic [3:0] mul);
    logic [23:0] w = '0;
    w[23] = sel; w[7:4] = mul; w[1:0] = 2'b01;
    return w;
  endfunction

  function automatic logic [23:0] val_w(input logic [12:0] v);
    logic [23:0] w = '0;
    w[15:3] = v; w[1:0] = 2'b10;
    return w;
  endfunction

  localparam logic [23:0] FREQ_W = 24'h5A5A00;

  task automatic wr(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      ser_data = w[i];
      #20 ser_clk = 1'b1;
      #20 ser_clk = 1'b0;
    end
    ser_latch = 1'b1;
    repeat (4) @(posedge clk);
    ser_latch = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_sync();
    do @(negedge clk); while (!sync_evt);
  endtask

  task automatic period(output int n);
    wait_sync();
    wait_sync();
    n = 0;
    do begin @(negedge clk); n++; end while (!sync_evt);
  endtask

  task automatic scan(input int cycles, output int syncs, output int pulses, output int idx);
    syncs = 0; pulses = 0; idx = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (sync_evt) syncs++;
      if (resync_pulse) begin
        pulses++;
        if (idx == 0) idx = syncs;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sync_evt == 0, "R10 sync_evt", sync_evt, 0);
    chk(resync_pulse == 0, "R10 resync_pulse", resync_pulse, 0);
    chk(config_err == 0, "R10 config_err", config_err, 0);
    scan(300, checks_dummy_s, checks_dummy_p, checks_dummy_i);
    chk(checks_dummy_s == 0, "R10 timer idle", checks_dummy_s, 0);
  endtask
  int checks_dummy_s, checks_dummy_p, checks_dummy_i;

  task automatic t_reference();
    int n;
    wr(val_w(13'd125));
    wr(ctrl_w(1'b1, 4'd10));
    wr(val_w(13'd1000));
    chk(config_err == 0, "R8 valid reference config", config_err, 0);
    period(n);
    chk(n == 10000, "R1 R3 reference period", n, 10000);
    @(negedge clk);
    chk(sync_evt == 0, "R1 event one cycle", sync_evt, 0);
  endtask

  task automatic t_short();
    int n;
    wr(ctrl_w(1'b1, 4'd3));
    wr(val_w(13'd250));
    period(n);
    chk(n == 750, "R1 period 3x250", n, 750);
  endtask

  task automatic t_second();
    int s, p, idx;
    wr(FREQ_W);
    scan(2270, s, p, idx);
    chk(p == 1, "R5 R7 one strobe", p, 1);
    chk(idx == 2, "R5 strobe on second event", idx, 2);
  endtask

  task automatic t_restart();
    int s, p, idx;
    wr(FREQ_W);
    wait_sync();
    chk(resync_pulse == 0, "R5 first event ignored", resync_pulse, 0);
    wr(FREQ_W);
    scan(2270, s, p, idx);
    chk(p == 1, "R6 one strobe after reload", p, 1);
    chk(idx == 2, "R6 count restarted", idx, 2);
  endtask

  task automatic t_err();
    int n;
    wr(val_w(13'd300));
    chk(config_err == 1, "R8 300 mod 125", config_err, 1);
    period(n);
    chk(n == 900, "R1 period 3x300", n, 900);
    wr(FREQ_W);
    chk(config_err == 1, "R9 sticky across freq word", config_err, 1);
    wr(val_w(13'd375));
    chk(config_err == 0, "R9 cleared by valid write", config_err, 0);
  endtask

  task automatic t_route();
    int n;
    wr(ctrl_w(1'b0, 4'd3));
    wr(val_w(13'd100));
    chk(config_err == 1, "R4 value routed to modulus", config_err, 1);
    period(n);
    chk(n == 1125, "R4 delay unchanged", n, 1125);
    wr(val_w(13'd125));
    chk(config_err == 0, "R4 modulus restored", config_err, 0);
  endtask

  task automatic t_disable();
    int s, p, idx;
    wr(ctrl_w(1'b1, 4'd0));
    wr(FREQ_W);
    scan(3000, s, p, idx);
    chk(s == 0, "R2 no events when disabled", s, 0);
    chk(p == 0, "R2 no strobe when disabled", p, 0);
    wr(val_w(13'd7));
    chk(config_err == 0, "R8 no error while disabled", config_err, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reference();
    t_short();
    t_second();
    t_restart();
    t_err();
    t_route();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule